// File: doc/BRIEF.md
# Memory Controller Configuration Register Block

This block is the software-visible configuration face of a memory controller. It sits on a simple device-control bus. The bus carries a read strobe, a write strobe, a register number, 32-bit write data and 32-bit read data. Most of the controller's internal registers are reached indirectly. Software first writes an index into an address register, then reads or writes a data register. Four bank registers sit directly on the bus and report a configuration word for each bank.

Each bank's configuration word is computed from base and size values fixed at elaboration, so software cannot change them. Only the controller-enable bit of the option register changes the block's behaviour. Turning it on raises a one-cycle map pulse on the line of every populated bank. Turning it off raises a one-cycle unmap pulse on the same lines. The memory fabric uses these pulses to open or close the address windows of the banks.

The bus has no back-pressure: each strobe is accepted in the cycle it is seen. Read data is registered and comes back with a valid flag one cycle after the read strobe. The requester must treat that flag as the only sign of completion.

Top module: `memcfg_regs`

## Requirements
- R1: A write to bus register 0x010 loads the full 32-bit indirect index. A read of 0x010 returns the last value written.
- R2: `rvalid` is high exactly in the cycle after a cycle with `bus_rd` high. `rdata` is zero whenever `rvalid` is low.
- R3: A read of bus register 0x040+i (i = 0..3) returns the configuration word of bank i. For a populated bank the word holds the base in 8 MiB units in bits 31:21, (1024 − size in 8 MiB units) in bits 15:6, a 1 in bit 0, and zeros elsewhere. Banks at or above the bank count, or with size zero, read zero. Writes to these registers leave their read value unchanged.
- R4: Bus registers 0x045, 0x04A, 0x04B, 0x04F and 0x050, like any unlisted bus register, read zero and ignore writes.
- R5: The option register is reached through index 0x21 on data register 0x011. It keeps only bit 27 (controller enable). A read returns that bit in place, with all other bits zero.
- R6: A write to the option register that changes the enable bit from 0 to 1 raises `bank_map[i]` for one cycle on every populated bank. A change from 1 to 0 raises `bank_unmap[i]` in the same way. The pulse appears in the cycle after the write strobe. Writing the current value raises no pulse.
- R7: Indirect reads through 0x011 return fixed values: 0x80000000 for indices 0x14 and 0x1F, 0x00008001 for index 0x40, and 0x02000000 for index 0x7A. Any other index except 0x21 returns zero.
- R8: Indirect writes to any index other than 0x21 leave every readable value unchanged and raise no pulse.
- R9: Reset clears the indirect index and the enable bit, and raises no pulse.
- R10: Map and unmap pulses never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_num | input | BUS_NUM_W | Register number |
| bus_wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, zero when not valid |
| rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| bank_map | output | 4 | One-cycle map pulse per bank |
| bank_unmap | output | 4 | One-cycle unmap pulse per bank |

## Verification
A wrong indirect index or enable bit shows one cycle after the next read strobe, as a wrong value on `rdata` from 0x010 or from index 0x21. A stale enable bit also shows at the next enable write, as a missing or duplicated pulse. A wrong bank word is visible on the first direct read of that bank. A decode fault that lets a write reach the wrong register shows on the read-back that follows each ignored write.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int MAX_BANKS = 4;
  localparam int DATA_W    = 32;
  localparam int BASE_W    = 11;
  localparam int SIZE_W    = 10;

  // direct bus register numbers
  localparam int NUM_IDX   = 'h010;
  localparam int NUM_DATA  = 'h011;
  localparam int NUM_BANK0 = 'h040;

  // indirect indices
  localparam logic [DATA_W-1:0] IX_OPTION = 32'h21;
  localparam logic [DATA_W-1:0] IX_STAT_A = 32'h14;
  localparam logic [DATA_W-1:0] IX_STAT_B = 32'h1F;
  localparam logic [DATA_W-1:0] IX_BCFG   = 32'h40;
  localparam logic [DATA_W-1:0] IX_DLL    = 32'h7A;

  localparam logic [DATA_W-1:0] VAL_READY = 32'h8000_0000;
  localparam logic [DATA_W-1:0] VAL_BCFG  = 32'h0000_8001;
  localparam logic [DATA_W-1:0] VAL_DLL   = 32'h0200_0000;

  localparam int EN_BIT = 27;

  function automatic logic [DATA_W-1:0] bank_word(logic [BASE_W-1:0] base_u,
                                                  logic [SIZE_W-1:0] size_u);
    logic [DATA_W-1:0] w;
    logic [SIZE_W:0]   span;
    w = '0;
    if (size_u != '0) begin
      span     = (SIZE_W+1)'(1 << SIZE_W) - {1'b0, size_u};
      w[31:21] = base_u;
      w[15:6]  = span[SIZE_W-1:0];
      w[0]     = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/memcfg_bank_words.sv
module memcfg_bank_words
  import memcfg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter logic [MAX_BANKS*BASE_W-1:0] BASES = '0,
  parameter logic [MAX_BANKS*SIZE_W-1:0] SIZES = '0
) (
  output logic [DATA_W-1:0]    words [MAX_BANKS],
  output logic [MAX_BANKS-1:0] populated
);
  for (genvar i = 0; i < MAX_BANKS; i++) begin : g_bank
    localparam logic [BASE_W-1:0] B = BASES[i*BASE_W +: BASE_W];
    localparam logic [SIZE_W-1:0] S = SIZES[i*SIZE_W +: SIZE_W];
    if (i < NUM_BANKS && S != '0) begin : g_pop
      assign words[i]     = bank_word(B, S);
      assign populated[i] = 1'b1;
    end else begin : g_empty
      assign words[i]     = '0;
      assign populated[i] = 1'b0;
    end
  end
endmodule

// File: rtl/memcfg_opt_reg.sv
module memcfg_opt_reg
  import memcfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 opt_wr,
  input  logic                 en_in,
  input  logic [MAX_BANKS-1:0] populated,
  output logic                 en_q,
  output logic [MAX_BANKS-1:0] map_p,
  output logic [MAX_BANKS-1:0] unmap_p
);
  logic rise, fall;
  assign rise = opt_wr &&  en_in && !en_q;
  assign fall = opt_wr && !en_in &&  en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      map_p   <= '0;
      unmap_p <= '0;
    end else begin
      if (opt_wr) en_q <= en_in;
      map_p   <= rise ? populated : '0;
      unmap_p <= fall ? populated : '0;
    end
  end
endmodule

// File: rtl/memcfg_read_mux.sv
module memcfg_read_mux
  import memcfg_pkg::*;
#(
  parameter int BUS_NUM_W = 10
) (
  input  logic [BUS_NUM_W-1:0] num,
  input  logic [DATA_W-1:0]    idx,
  input  logic                 en_q,
  input  logic [DATA_W-1:0]    words [MAX_BANKS],
  output logic [DATA_W-1:0]    data
);
  logic [DATA_W-1:0] ind;

  always_comb begin
    ind = '0;
    unique case (idx)
      IX_STAT_A, IX_STAT_B: ind = VAL_READY;
      IX_OPTION:            ind[EN_BIT] = en_q;
      IX_BCFG:              ind = VAL_BCFG;
      IX_DLL:               ind = VAL_DLL;
      default:              ind = '0;
    endcase
  end

  always_comb begin
    data = '0;
    if (num == BUS_NUM_W'(NUM_IDX))
      data = idx;
    else if (num == BUS_NUM_W'(NUM_DATA))
      data = ind;
    else if (num >= BUS_NUM_W'(NUM_BANK0) && num < BUS_NUM_W'(NUM_BANK0 + MAX_BANKS))
      data = words[num[1:0]];
  end
endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs
  import memcfg_pkg::*;
#(
  parameter int BUS_NUM_W = 10,
  parameter int NUM_BANKS = 4,
  parameter logic [MAX_BANKS*BASE_W-1:0] BANK_BASE_U = {11'd0, 11'd96, 11'd64, 11'd0},
  parameter logic [MAX_BANKS*SIZE_W-1:0] BANK_SIZE_U = {10'd0, 10'd8, 10'd32, 10'd64}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [BUS_NUM_W-1:0] bus_num,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          rdata,
  output logic                 rvalid,
  output logic [3:0]           bank_map,
  output logic [3:0]           bank_unmap
);
  logic [DATA_W-1:0]    idx_q;
  logic [DATA_W-1:0]    words [MAX_BANKS];
  logic [MAX_BANKS-1:0] populated;
  logic                 en_q;
  logic                 opt_wr;
  logic [DATA_W-1:0]    rd_next;

  assign opt_wr = bus_wr && bus_num == BUS_NUM_W'(NUM_DATA) && idx_q == IX_OPTION;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (bus_wr && bus_num == BUS_NUM_W'(NUM_IDX)) idx_q <= bus_wdata;
  end

  memcfg_bank_words #(
    .NUM_BANKS(NUM_BANKS), .BASES(BANK_BASE_U), .SIZES(BANK_SIZE_U)
  ) u_words (
    .words(words), .populated(populated)
  );

  memcfg_opt_reg u_opt (
    .clk(clk), .rst_n(rst_n), .opt_wr(opt_wr), .en_in(bus_wdata[EN_BIT]),
    .populated(populated), .en_q(en_q), .map_p(bank_map), .unmap_p(bank_unmap)
  );

  memcfg_read_mux #(.BUS_NUM_W(BUS_NUM_W)) u_mux (
    .num(bus_num), .idx(idx_q), .en_q(en_q), .words(words), .data(rd_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= bus_rd;
      rdata  <= bus_rd ? rd_next : '0;
    end
  end
endmodule

// File: rtl/memcfg_checker.sv
module memcfg_checker #(
  parameter int BUS_NUM_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [BUS_NUM_W-1:0] bus_num,
  input logic [31:0]          rdata,
  input logic                 rvalid,
  input logic [3:0]           bank_map,
  input logic [3:0]           bank_unmap
);
  assert_rvalid_follows_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rvalid);
  assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rvalid);
  assert_rdata_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == 32'h0);
  assert_map_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_map) |-> $past(bus_wr && bus_num == BUS_NUM_W'('h011)));
  assert_unmap_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_unmap) |-> $past(bus_wr && bus_num == BUS_NUM_W'('h011)));
  assert_map_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_map) |=> bank_map == 4'h0);
  assert_unmap_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_unmap) |=> bank_unmap == 4'h0);
  assert_no_map_and_unmap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !((|bank_map) && (|bank_unmap)));
endmodule

bind memcfg_regs memcfg_checker #(.BUS_NUM_W(BUS_NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_num(bus_num),
  .rdata(rdata), .rvalid(rvalid), .bank_map(bank_map), .bank_unmap(bank_unmap)
);

// File: tb/tb_memcfg_regs.sv
`timescale 1ns/1ps
module tb_memcfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_num = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [3:0]  bank_map, bank_unmap;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  memcfg_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_num(bus_num),
    .bus_wdata(bus_wdata), .rdata(rdata), .rvalid(rvalid),
    .bank_map(bank_map), .bank_unmap(bank_unmap)
  );

  // {wr, num[9:0], wdata[31:0], expected[31:0]}; for writes expected = {unmap, map}
  localparam int NV = 38;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 10'h010, 32'h0,         32'h0},         // R9 index after reset
    {1'b1, 10'h010, 32'hDEADBEEF,  32'h0},
    {1'b0, 10'h010, 32'h0,         32'hDEADBEEF},  // R1
    {1'b0, 10'h040, 32'h0,         32'h0000F001},  // R3
    {1'b0, 10'h041, 32'h0,         32'h0800F801},  // R3
    {1'b0, 10'h042, 32'h0,         32'h0C00FE01},  // R3
    {1'b0, 10'h043, 32'h0,         32'h0},         // R3 empty
    {1'b1, 10'h041, 32'hFFFFFFFF,  32'h0},
    {1'b0, 10'h041, 32'h0,         32'h0800F801},  // R3 write ignored
    {1'b1, 10'h045, 32'h12345678,  32'h0},
    {1'b0, 10'h045, 32'h0,         32'h0},         // R4
    {1'b1, 10'h04A, 32'hFFFFFFFF,  32'h0},
    {1'b0, 10'h04A, 32'h0,         32'h0},         // R4
    {1'b0, 10'h04B, 32'h0,         32'h0},         // R4
    {1'b0, 10'h04F, 32'h0,         32'h0},         // R4
    {1'b0, 10'h050, 32'h0,         32'h0},         // R4
    {1'b1, 10'h010, 32'h14,        32'h0},
    {1'b0, 10'h011, 32'h0,         32'h80000000},  // R7
    {1'b1, 10'h010, 32'h1F,        32'h0},
    {1'b0, 10'h011, 32'h0,         32'h80000000},  // R7
    {1'b1, 10'h010, 32'h40,        32'h0},
    {1'b0, 10'h011, 32'h0,         32'h00008001},  // R7
    {1'b1, 10'h011, 32'h0,         32'h0},         // R8 no pulse
    {1'b0, 10'h011, 32'h0,         32'h00008001},  // R8 unchanged
    {1'b1, 10'h010, 32'h7A,        32'h0},
    {1'b0, 10'h011, 32'h0,         32'h02000000},  // R7
    {1'b1, 10'h010, 32'h33,        32'h0},
    {1'b1, 10'h011, 32'hFFFFFFFF,  32'h0},         // R8 no pulse
    {1'b0, 10'h011, 32'h0,         32'h0},         // R7 other index
    {1'b1, 10'h010, 32'h21,        32'h0},
    {1'b1, 10'h011, 32'hF7FFFFFF,  32'h0},         // R5 bit 27 clear
    {1'b0, 10'h011, 32'h0,         32'h0},         // R5
    {1'b1, 10'h011, 32'hFFFFFFFF,  32'h00000007},  // R6 map populated
    {1'b0, 10'h011, 32'h0,         32'h08000000},  // R5
    {1'b1, 10'h011, 32'h08000000,  32'h0},         // R6 same value
    {1'b1, 10'h011, 32'h0,         32'h00000070},  // R6 unmap
    {1'b0, 10'h011, 32'h0,         32'h0},         // R5
    {1'b0, 10'h010, 32'h0,         32'h21}         // R1
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [9:0] n, logic [31:0] d, output logic [7:0] pulses);
    @(negedge clk);
    bus_wr = 1'b1; bus_num = n; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    pulses = {bank_unmap, bank_map};
  endtask

  task automatic do_read(logic [9:0] n, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_num = n;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata; v = rvalid;
  endtask

  initial begin
    logic [31:0] d;
    logic        v;
    logic [7:0]  p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 rvalid idle", {31'h0, rvalid}, 32'h0);
    check("R9 no pulse after reset", {24'h0, bank_unmap, bank_map}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][74]) begin
        do_write(VEC[i][73:64], VEC[i][63:32], p);
        check($sformatf("R6/R8 vec%0d pulses", i), {24'h0, p}, VEC[i][31:0]);
      end else begin
        do_read(VEC[i][73:64], d, v);
        check($sformatf("R2 vec%0d rvalid", i), {31'h0, v}, 32'h1);
        check($sformatf("R1/R3/R4/R5/R7 vec%0d data", i), d, VEC[i][31:0]);
      end
    end

    // R6 pulse lasts one cycle
    do_write(10'h011, 32'h08000000, p);
    check("R6 map pulse", {24'h0, p}, 32'h07);
    @(negedge clk);
    check("R6 map one cycle", {28'h0, bank_map}, 32'h0);
    check("R2 rdata zero when idle", rdata, 32'h0);

    // R9 reset while enabled clears index and enable, no pulse
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 no unmap on reset", {28'h0, bank_unmap}, 32'h0);
    do_read(10'h010, d, v);
    check("R9 index cleared", d, 32'h0);
    do_write(10'h010, 32'h21, p);
    do_read(10'h011, d, v);
    check("R9 enable cleared", d, 32'h0);
    do_write(10'h011, 32'h08000000, p);
    check("R6 map after reset", {24'h0, p}, 32'h07);
    do_write(10'h011, 32'h00000000, p);
    check("R10 unmap only", {24'h0, p}, 32'h70);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule